// File: doc/BRIEF.md
# Load-Use Stall Detector

This block decides, cycle by cycle, whether the front end of a five-stage in-order pipeline has to freeze for one cycle. It checks whether the instruction in execute is a load whose destination register is a source of the instruction now in decode. The load data only exists after the memory stage, so forwarding cannot supply it to the very next instruction. The block then holds the program counter and the fetch/decode pipeline register. It also tells the control mux at the entry of the decode/execute register to insert a no-operation (a bubble). After that single bubble, the memory/writeback forwarding path delivers the loaded value, so no further stall is needed.

The decision is purely combinational from the current pipeline register contents. A source operand counts only when its use flag is set, so immediate-form and jump instructions do not stall on fields they ignore. A producer counts only when it really writes a register and reads memory. Register 0 is treated as a constant and never takes part in a hazard.

Top module: `load_use_hazard`

## Requirements
- R1: When the execute instruction has both reg-write and mem-read set, its destination is nonzero and equals source slot 0 of decode with use flag 0 set, then pc_write_en = 0, ifid_write_en = 0 and bubble_sel = 1.
- R2: The same stall results when the match is on source slot 1 (bits [9:5] of id_src) with use flag 1 set.
- R3: With mem-read clear in execute (an ALU result, covered by forwarding), no stall occurs, whatever the specifiers are.
- R4: With reg-write clear in execute (for example a store), no stall occurs even when mem-read is set and the specifiers match.
- R5: A source slot whose use flag is clear never causes a stall, even when it equals the load destination.
- R6: A load whose destination is register 0 never causes a stall.
- R7: When no used nonzero source equals the load destination, pc_write_en = 1, ifid_write_en = 1 and bubble_sel = 0 (normal flow).
- R8: At all times pc_write_en equals ifid_write_en, and both are the inverse of bubble_sel.
- R9: A load matching both source slots at once produces the same single stall pattern as one match.
- R10: The outputs follow input changes in the same cycle, with no clock edge between stimulus and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src | input | 10 | Decode source specifiers, slot 0 in [4:0], slot 1 in [9:5] |
| id_src_used | input | 2 | Per-slot flag: the decode instruction actually reads that operand |
| ex_dst | input | 5 | Destination specifier of the execute instruction |
| ex_reg_write | input | 1 | Execute instruction writes a register |
| ex_mem_read | input | 1 | Execute instruction reads data memory (load) |
| pc_write_en | output | 1 | Program counter may advance |
| ifid_write_en | output | 1 | Fetch/decode pipeline register may load |
| bubble_sel | output | 1 | Select the no-operation input of the control mux |

## Verification
Every result of this block is due in the same cycle as its stimulus, zero clock edges later, because no register lies between the inputs and the three outputs. The bench changes the inputs on the falling clock edge, lets them settle for a short delay, and samples the outputs before the next rising edge. A wrongly inserted register, or a missed update, therefore shows up as a stale value at the sample point. Each scenario puts a nonzero, non-matching pattern on the inputs first, so a result left over from the previous scenario is also caught.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Control outputs towards the front end and the bubble mux
    typedef struct packed {
        logic pc_write_en;
        logic ifid_write_en;
        logic bubble_sel;
    } stall_ctl_t;

    localparam stall_ctl_t FLOW_CTL  = '{pc_write_en: 1'b1, ifid_write_en: 1'b1, bubble_sel: 1'b0};
    localparam stall_ctl_t FREEZE_CTL = '{pc_write_en: 1'b0, ifid_write_en: 1'b0, bubble_sel: 1'b1};

endpackage

// File: rtl/hazard_src_match.sv
module hazard_src_match #(
    parameter int REG_W        = 5,
    parameter bit ZERO_IS_CONST = 1'b1
) (
    input  logic [REG_W-1:0] src,
    input  logic             src_used,
    input  logic [REG_W-1:0] producer_dst,
    input  logic             producer_is_load,
    output logic             hit
);
    logic dst_live;
    logic hit_d;

    generate
        if (ZERO_IS_CONST) begin : g_zero_const
            assign dst_live = producer_is_load && (producer_dst != '0);
        end else begin : g_zero_plain
            assign dst_live = producer_is_load;
        end
    endgenerate

    always_comb begin
        hit_d = src_used && dst_live && (src == producer_dst);
    end

    assign hit = hit_d;

endmodule

// File: rtl/hazard_stall_gen.sv
module hazard_stall_gen
    import hazard_pkg::*;
#(
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0] src_hit,
    output stall_ctl_t         ctl
);
    stall_ctl_t ctl_d;

    always_comb begin
        ctl_d = FLOW_CTL;
        if (|src_hit) begin
            ctl_d = FREEZE_CTL;
        end
    end

    assign ctl = ctl_d;

endmodule

// File: rtl/load_use_hazard.sv
module load_use_hazard
    import hazard_pkg::*;
#(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic [NUM_SRC-1:0][REG_W-1:0] id_src,
    input  logic [NUM_SRC-1:0]            id_src_used,
    input  logic [REG_W-1:0]              ex_dst,
    input  logic                          ex_reg_write,
    input  logic                          ex_mem_read,
    output logic                          pc_write_en,
    output logic                          ifid_write_en,
    output logic                          bubble_sel
);
    logic                ex_is_load_d;
    logic [NUM_SRC-1:0]  src_hit;
    stall_ctl_t          ctl;

    // A producer only matters if it is a load that writes a register
    always_comb begin
        ex_is_load_d = ex_reg_write && ex_mem_read;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            hazard_src_match #(
                .REG_W         (REG_W),
                .ZERO_IS_CONST (1'b1)
            ) match_i (
                .src              (id_src[g]),
                .src_used         (id_src_used[g]),
                .producer_dst     (ex_dst),
                .producer_is_load (ex_is_load_d),
                .hit              (src_hit[g])
            );
        end
    endgenerate

    hazard_stall_gen #(
        .NUM_SRC (NUM_SRC)
    ) stall_i (
        .src_hit (src_hit),
        .ctl     (ctl)
    );

    assign pc_write_en   = ctl.pc_write_en;
    assign ifid_write_en = ctl.ifid_write_en;
    assign bubble_sel    = ctl.bubble_sel;

endmodule

// File: rtl/load_use_hazard_chk.sv
module load_use_hazard_chk #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input logic [NUM_SRC-1:0][REG_W-1:0] id_src,
    input logic [NUM_SRC-1:0]            id_src_used,
    input logic [REG_W-1:0]              ex_dst,
    input logic                          ex_reg_write,
    input logic                          ex_mem_read,
    input logic                          pc_write_en,
    input logic                          ifid_write_en,
    input logic                          bubble_sel
);
    logic known;
    logic used_match;

    always_comb begin
        known = !$isunknown({id_src, id_src_used, ex_dst, ex_reg_write, ex_mem_read,
                             pc_write_en, ifid_write_en, bubble_sel});
        used_match = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (id_src_used[i] && (id_src[i] == ex_dst)) used_match = 1'b1;
        end

        if (known) begin
            // R1 / R2: a live load feeding a used source freezes the front end
            if (ex_reg_write && ex_mem_read && (ex_dst != '0) && used_match)
                p_load_use_stall_r1: assert (bubble_sel && !pc_write_en);
            // R3: ALU producers are left to forwarding
            if (!ex_mem_read)
                p_alu_no_stall_r3: assert (!bubble_sel);
            // R4: non-writing producer never stalls
            if (!ex_reg_write)
                p_nowrite_no_stall_r4: assert (!bubble_sel);
            // R5: a stall requires some used operand to match
            if (bubble_sel)
                p_unused_ignored_r5: assert (used_match);
            // R6: register 0 is constant
            if (ex_dst == '0)
                p_zero_reg_no_stall_r6: assert (!bubble_sel);
            // R8: three controls always agree
            p_ctl_agree_r8: assert ((pc_write_en == ifid_write_en) && (pc_write_en == !bubble_sel));
        end
    end

endmodule

bind load_use_hazard load_use_hazard_chk #(
    .REG_W   (REG_W),
    .NUM_SRC (NUM_SRC)
) chk_i (
    .id_src        (id_src),
    .id_src_used   (id_src_used),
    .ex_dst        (ex_dst),
    .ex_reg_write  (ex_reg_write),
    .ex_mem_read   (ex_mem_read),
    .pc_write_en   (pc_write_en),
    .ifid_write_en (ifid_write_en),
    .bubble_sel    (bubble_sel)
);

// File: tb/load_use_hazard_tb_top.sv
module load_use_hazard_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic [1:0][4:0] id_src      = '0;
    logic [1:0]      id_src_used = '0;
    logic [4:0]      ex_dst      = '0;
    logic            ex_reg_write = 1'b0;
    logic            ex_mem_read  = 1'b0;
    logic            pc_write_en;
    logic            ifid_write_en;
    logic            bubble_sel;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    load_use_hazard dut_i (
        .id_src        (id_src),
        .id_src_used   (id_src_used),
        .ex_dst        (ex_dst),
        .ex_reg_write  (ex_reg_write),
        .ex_mem_read   (ex_mem_read),
        .pc_write_en   (pc_write_en),
        .ifid_write_en (ifid_write_en),
        .bubble_sel    (bubble_sel)
    );

    // Drive on the falling edge; results are combinational, sample 1ns later
    task automatic drive(input logic [4:0] s0, input logic [4:0] s1, input logic [1:0] used,
                         input logic [4:0] dst, input logic rw, input logic mr);
        @(negedge clk);
        id_src[0]    = s0;
        id_src[1]    = s1;
        id_src_used  = used;
        ex_dst       = dst;
        ex_reg_write = rw;
        ex_mem_read  = mr;
        #1ns;
    endtask

    task automatic expect_ctl(input bit stall, input string req);
        logic [2:0] act, exp;
        act = {pc_write_en, ifid_write_en, bubble_sel};
        exp = stall ? 3'b001 : 3'b110;
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: {pc,ifid,bubble} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Puts a clean non-stalling pattern on first so stale results show up
    task automatic preset();
        drive(5'd3, 5'd4, 2'b11, 5'd9, 1'b1, 1'b1);
        expect_ctl(1'b0, "R7");
    endtask

    task automatic t_idle();
        expect_ctl(1'b0, "R7 idle");
    endtask

    task automatic t_match_slot0();
        preset();
        drive(5'd7, 5'd12, 2'b11, 5'd7, 1'b1, 1'b1);
        expect_ctl(1'b1, "R1");
        drive(5'd31, 5'd1, 2'b01, 5'd31, 1'b1, 1'b1);
        expect_ctl(1'b1, "R1 reg31");
    endtask

    task automatic t_match_slot1();
        preset();
        drive(5'd2, 5'd18, 2'b10, 5'd18, 1'b1, 1'b1);
        expect_ctl(1'b1, "R2");
    endtask

    task automatic t_alu_producer();
        preset();
        drive(5'd6, 5'd6, 2'b11, 5'd6, 1'b1, 1'b0);
        expect_ctl(1'b0, "R3");
    endtask

    task automatic t_no_write();
        preset();
        drive(5'd5, 5'd5, 2'b11, 5'd5, 1'b0, 1'b1);
        expect_ctl(1'b0, "R4");
    endtask

    task automatic t_unused();
        preset();
        drive(5'd1, 5'd11, 2'b01, 5'd11, 1'b1, 1'b1);
        expect_ctl(1'b0, "R5 slot1 unused");
        drive(5'd11, 5'd1, 2'b10, 5'd11, 1'b1, 1'b1);
        expect_ctl(1'b0, "R5 slot0 unused");
    endtask

    task automatic t_zero();
        preset();
        drive(5'd0, 5'd0, 2'b11, 5'd0, 1'b1, 1'b1);
        expect_ctl(1'b0, "R6");
    endtask

    task automatic t_mismatch();
        drive(5'd8, 5'd16, 2'b11, 5'd24, 1'b1, 1'b1);
        expect_ctl(1'b0, "R7");
        drive(5'd1, 5'd2, 2'b11, 5'd3, 1'b1, 1'b1);
        expect_ctl(1'b0, "R7 near");
    endtask

    task automatic t_both();
        preset();
        drive(5'd14, 5'd14, 2'b11, 5'd14, 1'b1, 1'b1);
        expect_ctl(1'b1, "R9");
    endtask

    task automatic t_same_cycle();
        // R10: change inputs mid-cycle twice within one low phase
        drive(5'd20, 5'd0, 2'b01, 5'd20, 1'b1, 1'b1);
        expect_ctl(1'b1, "R10 set");
        ex_mem_read = 1'b0;
        #1ns;
        expect_ctl(1'b0, "R10 clear");
        n_checks++;
        if (pc_write_en !== ifid_write_en || pc_write_en !== !bubble_sel) begin
            n_fails++;
            $display("FAIL R8: pc=%b ifid=%b bubble=%b expected pc=ifid=!bubble",
                     pc_write_en, ifid_write_en, bubble_sel);
        end
    endtask

    initial begin
        #1ns;
        t_idle();
        t_match_slot0();
        t_match_slot1();
        t_alu_producer();
        t_no_write();
        t_unused();
        t_zero();
        t_mismatch();
        t_both();
        t_same_cycle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule